// File: doc/BRIEF.md
# Dual-Mode Host Bus Cycle Controller

This block sits between a host processor bus and a peripheral's register file. It decodes each host access from a chip enable, a read/write select, an address and write data. It gives the register file one read or write strobe per access, and it returns read data together with a data acknowledge. It also holds one configuration register of its own. The register file is outside the block: it reads combinationally from the request address that the block drives.

After reset the controller runs handshaken cycles. The host keeps chip enable low for as long as it likes. The acknowledge appears a fixed number of clocks after the start and stays up until the host releases chip enable. Software can move the controller into a synchronous mode in which every access takes a fixed four clocks and chip enable may stay low across back-to-back accesses. To do so, it writes the configuration register with the mode bit set. The change happens when chip enable rises at the end of that write. A two-clock guard interval follows, and any cycle the host tries to start inside it is dropped and recorded in a sticky error flag. Synchronous mode is left only by reset.

A lock bit in the configuration register cuts the host off from the register file. The configuration register itself stays reachable.

Top module: `hbc_host_bus`

## Requirements
- R1: While `rst` is high and in the first clock after it falls, `dack_o`, `reg_wr_stb_o`, `reg_rd_stb_o` and `gap_err_o` are 0 and `rdata_o` is 0x00. The controller is in handshaken mode, and the configuration register reads 0x00.
- R2: Handshaken mode, cycle start: a cycle starts at the clock edge that first samples `ce_n_i` low. `dack_o` rises two clock edges after that start.
- R2b: Handshaken mode, cycle end: `dack_o` stays high while `ce_n_i` stays low and falls at the first edge that samples `ce_n_i` high.
- R3: Each access to the register file gives exactly one strobe (`reg_wr_stb_o` for writes, `reg_rd_stb_o` for reads), one clock long, in the first clock that `dack_o` is high. During it, `reg_addr_o` and `reg_wdata_o` carry the address and data captured at the cycle start. For a read, `rdata_o` holds `reg_rdata_i` from that same clock.
- R4: The configuration register answers at both addresses 0x0F and 0x8F, and an access to it raises no strobe. A read returns the stored byte with bit 6 replaced by the current mode (1 = synchronous).
- R5: A handshaken write to the configuration register with bit 6 = 1 switches the controller to synchronous mode at the edge that ends that write (the first edge sampling `ce_n_i` high). The write itself still completes with handshaken timing.
- R6: For the two clock edges after the switching edge, a low `ce_n_i` starts no access: no `dack_o` and no strobe. It also sets `gap_err_o`, which then stays 1 until reset.
- R7: In synchronous mode an access started at an edge sampling `ce_n_i` low runs four clocks. `dack_o` and the strobe are high in the fourth clock only.
- R8: In synchronous mode, if `ce_n_i` is still low at the edge that ends an access, a new access starts there. It captures the address, direction and data present at that edge, so accesses follow every four clocks.
- R9: Once synchronous, a configuration write with bit 6 = 0 does not leave that mode. Only `rst` returns the controller to handshaken mode.
- R10: Bit 7 of the configuration register is a lock. While it is 1, register file accesses still acknowledge but raise no strobe and read 0x00. The configuration register stays readable and writable, so writing bit 7 = 0 unlocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n_i | input | 1 | Host chip enable, active low |
| wr_i | input | 1 | Access direction, 1 = write, 0 = read |
| addr_i | input | 8 | Host address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data returned to the host |
| dack_o | output | 1 | Data acknowledge |
| reg_wr_stb_o | output | 1 | Register file write strobe |
| reg_rd_stb_o | output | 1 | Register file read strobe |
| reg_addr_o | output | 8 | Register file address (captured request) |
| reg_wdata_o | output | 8 | Register file write data (captured request) |
| reg_rdata_i | input | 8 | Register file read data for `reg_addr_o` |
| gap_err_o | output | 1 | Sticky flag: a cycle was attempted inside the guard interval |

## Verification
The guard-interval violation is the hardest case to reach from the ports. It exists only in the two clocks after a switching write has ended. The stimulus completes a handshaken configuration write with bit 6 set, releases chip enable, and pulls chip enable low again in the very next clock. It then checks that no acknowledge or strobe appears, that the error flag rises, and that a later properly spaced synchronous access still runs in four clocks. The one-way nature of the switch is checked from the ports alone: the bench watches the cycle length and reads back the mode bit after a write that tries to clear it.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 8;
    localparam int CFG_MODE_BIT = 6;
    localparam int CFG_LOCK_BIT = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_HOLD,
        ST_GAP
    } bus_st_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic hits_cfg(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] alias_a,
                                      input logic [ADDR_W-1:0] alias_b);
        return (a == alias_a) || (a == alias_b);
    endfunction

endpackage

// File: rtl/hbc_cycle_fsm.sv
module hbc_cycle_fsm
    import hbc_pkg::*;
#(
    parameter int ASYNC_WAIT = 2,
    parameter int SYNC_LEN   = 4,
    parameter int GAP_LEN    = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ce_n,
    input  logic    sync_mode,
    input  logic    switch_pend,
    output bus_st_e st,
    output logic    take_req,
    output logic    enter_xfer,
    output logic    commit_sync,
    output logic    gap_err
);

    localparam int MAX_A   = (ASYNC_WAIT > SYNC_LEN) ? ASYNC_WAIT : SYNC_LEN;
    localparam int MAX_LEN = (MAX_A > GAP_LEN) ? MAX_A : GAP_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] ASYNC_LAST = CNT_W'(ASYNC_WAIT - 1);
    localparam logic [CNT_W-1:0] SYNC_LAST  = CNT_W'(SYNC_LEN - 2);
    localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_LEN - 1);

    bus_st_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             err_q, err_d;
    logic [CNT_W-1:0] wait_last;

    always_comb begin
        st_d        = st_q;
        cnt_d       = cnt_q;
        err_d       = err_q;
        take_req    = 1'b0;
        enter_xfer  = 1'b0;
        commit_sync = 1'b0;
        wait_last   = sync_mode ? SYNC_LAST : ASYNC_LAST;
        unique case (st_q)
            ST_IDLE: begin
                if (!ce_n) begin
                    st_d     = ST_WAIT;
                    cnt_d    = '0;
                    take_req = 1'b1;
                end
            end
            ST_WAIT: begin
                if (cnt_q == wait_last) begin
                    st_d       = ST_XFER;
                    enter_xfer = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_XFER, ST_HOLD: begin
                if (sync_mode) begin
                    if (!ce_n) begin
                        st_d     = ST_WAIT;
                        cnt_d    = '0;
                        take_req = 1'b1;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end else if (ce_n) begin
                    if (switch_pend) begin
                        st_d        = ST_GAP;
                        cnt_d       = '0;
                        commit_sync = 1'b1;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end else begin
                    st_d = ST_HOLD;
                end
            end
            ST_GAP: begin
                if (!ce_n) err_d = 1'b1;
                if (cnt_q == GAP_LAST) st_d = ST_IDLE;
                else cnt_d = cnt_q + 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            err_q <= err_d;
        end
    end

    assign st      = st_q;
    assign gap_err = err_q;

    // R6: the error flag is sticky
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R5: the guard interval is entered only from a handshaken cycle
    assert_gap_from_async_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_GAP) && (st_d == ST_GAP) |-> !sync_mode);

endmodule

// File: rtl/hbc_cfg_reg.sv
module hbc_cfg_reg
    import hbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              commit_sync,
    output logic [DATA_W-1:0] cfg_view,
    output logic              sync_mode,
    output logic              lock,
    output logic              switch_pend
);

    logic [DATA_W-1:0] cfg_q;
    logic              sync_q;
    logic              pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            sync_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (wr_en) begin
                cfg_q <= wdata;
                if (!sync_q && wdata[CFG_MODE_BIT]) pend_q <= 1'b1;
            end
            if (commit_sync) begin
                sync_q <= 1'b1;
                pend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        cfg_view               = cfg_q;
        cfg_view[CFG_MODE_BIT] = sync_q;
    end

    assign sync_mode   = sync_q;
    assign lock        = cfg_q[CFG_LOCK_BIT];
    assign switch_pend = pend_q;

    // R9: synchronous mode is never left without reset
    assert_mode_one_way_R9: assert property (@(posedge clk) disable iff (rst)
        sync_q |=> sync_q);

    // R5: a pending switch exists only while still handshaken
    assert_pend_async_R5: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> !sync_q);

endmodule

// File: rtl/hbc_access_dec.sv
module hbc_access_dec
    import hbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_st_e           st,
    input  logic              enter_xfer,
    input  bus_req_t          req,
    input  logic              cfg_hit,
    input  logic              lock,
    input  logic [DATA_W-1:0] cfg_view,
    input  logic [DATA_W-1:0] file_rdata,
    output logic              dack,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic [DATA_W-1:0] rdata
);

    logic              file_ok;
    logic [DATA_W-1:0] rd_sel;
    logic [DATA_W-1:0] rdata_q;

    assign file_ok = (st == ST_XFER) && !cfg_hit && !lock;
    assign wr_stb  = file_ok && req.wr;
    assign rd_stb  = file_ok && !req.wr;
    assign dack    = (st == ST_XFER) || (st == ST_HOLD);

    always_comb begin
        if (cfg_hit)   rd_sel = cfg_view;
        else if (lock) rd_sel = '0;
        else           rd_sel = file_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                        rdata_q <= '0;
        else if (enter_xfer && !req.wr) rdata_q <= rd_sel;
    end

    assign rdata = rdata_q;

    // R3: a strobe lasts one clock
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_stb || rd_stb) |=> !(wr_stb || rd_stb));

endmodule

// File: rtl/hbc_host_bus.sv
module hbc_host_bus
    import hbc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CFG_ADDR_A = 8'h0F,
    parameter logic [ADDR_W-1:0] CFG_ADDR_B = 8'h8F,
    parameter int                ASYNC_WAIT = 2,
    parameter int                SYNC_LEN   = 4,
    parameter int                GAP_LEN    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              dack_o,
    output logic              reg_wr_stb_o,
    output logic              reg_rd_stb_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    input  logic [DATA_W-1:0] reg_rdata_i,
    output logic              gap_err_o
);

    bus_st_e           st;
    bus_req_t          req_q;
    logic              take_req, enter_xfer, commit_sync;
    logic              sync_mode, lock, switch_pend, cfg_hit;
    logic [DATA_W-1:0] cfg_view;

    always_ff @(posedge clk) begin
        if (rst)           req_q <= '0;
        else if (take_req) req_q <= '{wr: wr_i, addr: addr_i, wdata: wdata_i};
    end

    assign cfg_hit = hits_cfg(req_q.addr, CFG_ADDR_A, CFG_ADDR_B);

    hbc_cycle_fsm #(
        .ASYNC_WAIT(ASYNC_WAIT),
        .SYNC_LEN  (SYNC_LEN),
        .GAP_LEN   (GAP_LEN)
    ) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .ce_n       (ce_n_i),
        .sync_mode  (sync_mode),
        .switch_pend(switch_pend),
        .st         (st),
        .take_req   (take_req),
        .enter_xfer (enter_xfer),
        .commit_sync(commit_sync),
        .gap_err    (gap_err_o)
    );

    hbc_cfg_reg cfg_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (enter_xfer && req_q.wr && cfg_hit),
        .wdata      (req_q.wdata),
        .commit_sync(commit_sync),
        .cfg_view   (cfg_view),
        .sync_mode  (sync_mode),
        .lock       (lock),
        .switch_pend(switch_pend)
    );

    hbc_access_dec dec_i (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .enter_xfer(enter_xfer),
        .req       (req_q),
        .cfg_hit   (cfg_hit),
        .lock      (lock),
        .cfg_view  (cfg_view),
        .file_rdata(reg_rdata_i),
        .dack      (dack_o),
        .wr_stb    (reg_wr_stb_o),
        .rd_stb    (reg_rd_stb_o),
        .rdata     (rdata_o)
    );

    assign reg_addr_o  = req_q.addr;
    assign reg_wdata_o = req_q.wdata;

    // checker state: consecutive clocks with chip enable sampled low
    logic [7:0] lo_run_q;
    always_ff @(posedge clk) begin
        if (rst || ce_n_i)          lo_run_q <= '0;
        else if (lo_run_q != 8'hFF) lo_run_q <= lo_run_q + 1'b1;
    end

    // R2: handshaken acknowledge appears a fixed delay after the start
    assert_async_ack_delay_R2: assert property (@(posedge clk) disable iff (rst)
        (!sync_mode && $rose(dack_o)) |-> (lo_run_q == 8'(ASYNC_WAIT + 1)));

    // R7: synchronous acknowledge is a single-clock pulse
    assert_sync_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && dack_o) |=> !dack_o);

    // R6: no acknowledge right after the mode switch
    assert_gap_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_mode) |-> !dack_o);

    // R10: strobes imply acknowledge
    assert_stb_has_ack_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_stb_o || reg_rd_stb_o) |-> dack_o);

endmodule

// File: tb/hbc_host_bus_tb_top.sv
`timescale 1ns/100ps
module hbc_host_bus_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_n = 1'b1;
    logic       wr = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, reg_addr, reg_wdata, reg_rdata;
    logic       dack, wstb, rstb, gerr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    // register file model: combinational read
    assign reg_rdata = reg_addr ^ 8'h5A;

    hbc_host_bus dut_i (
        .clk         (clk),
        .rst         (rst),
        .ce_n_i      (ce_n),
        .wr_i        (wr),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .dack_o      (dack),
        .reg_wr_stb_o(wstb),
        .reg_rd_stb_o(rstb),
        .reg_addr_o  (reg_addr),
        .reg_wdata_o (reg_wdata),
        .reg_rdata_i (reg_rdata),
        .gap_err_o   (gerr)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] addr;
        logic [7:0] wdata;
        logic [7:0] exp;
        logic       to_file;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 8'h22, 8'h3C, 8'h00, 1'b1},
        '{1'b0, 8'h22, 8'h00, 8'h78, 1'b1},
        '{1'b1, 8'h0F, 8'h15, 8'h00, 1'b0},
        '{1'b0, 8'h8F, 8'h00, 8'h15, 1'b0},
        '{1'b0, 8'h0F, 8'h00, 8'h15, 1'b0},
        '{1'b1, 8'h8F, 8'h00, 8'h00, 1'b0},
        '{1'b0, 8'h0F, 8'h00, 8'h00, 1'b0},
        '{1'b0, 8'hA7, 8'h00, 8'hFD, 1'b1},
        '{1'b1, 8'h7E, 8'hFF, 8'h00, 1'b1}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic check_xfer(input string rq, input logic w, input logic [7:0] a,
                              input logic [7:0] d, input logic f, input logic [7:0] e);
        chk(rq, {31'd0, wstb}, {31'd0, w && f});
        chk(rq, {31'd0, rstb}, {31'd0, !w && f});
        if (w && f) begin
            chk(rq, {24'd0, reg_addr}, {24'd0, a});
            chk(rq, {24'd0, reg_wdata}, {24'd0, d});
        end
        if (!w) chk(rq, {24'd0, rdata}, {24'd0, e});
    endtask

    // called at a negedge; returns at the negedge after the closing edge
    task automatic async_cyc(input string rq, input logic w, input logic [7:0] a,
                             input logic [7:0] d, input logic f, input logic [7:0] e);
        int n;
        ce_n = 1'b0; wr = w; addr = a; wdata = d;
        n = 0;
        do begin @(negedge clk); n++; end while (!dack && n < 12);
        chk("R2", n, 3);
        check_xfer(rq, w, a, d, f, e);
        @(negedge clk);
        chk("R2b", {31'd0, dack}, 32'd1);
        chk("R3", {31'd0, wstb || rstb}, 32'd0);
        ce_n = 1'b1;
        @(negedge clk);
        chk("R2b", {31'd0, dack}, 32'd0);
    endtask

    task automatic sync_cyc(input string rq, input logic w, input logic [7:0] a,
                            input logic [7:0] d, input logic f, input logic [7:0] e,
                            input bit last);
        int n;
        ce_n = 1'b0; wr = w; addr = a; wdata = d;
        n = 0;
        do begin @(negedge clk); n++; end while (!dack && n < 12);
        chk("R7", n, 4);
        check_xfer(rq, w, a, d, f, e);
        if (last) begin
            ce_n = 1'b1;
            @(negedge clk);
            chk("R7", {31'd0, dack}, 32'd0);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; ce_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", {30'd0, dack, wstb || rstb}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {31'd0, dack}, 32'd0);
        chk("R1", {31'd0, wstb || rstb}, 32'd0);
        chk("R1", {31'd0, gerr}, 32'd0);
        chk("R1", {24'd0, rdata}, 32'd0);
    endtask

    initial begin
        do_reset();

        // table walk: handshaken accesses to the file and the config register
        for (int i = 0; i < NV; i++) begin
            async_cyc(TBL[i].to_file ? "R3" : "R4", TBL[i].wr, TBL[i].addr,
                      TBL[i].wdata, TBL[i].to_file, TBL[i].exp);
        end

        // R10: lock bit
        async_cyc("R10", 1'b1, 8'h0F, 8'h80, 1'b0, 8'h00);
        async_cyc("R10", 1'b1, 8'h10, 8'h99, 1'b0, 8'h00);
        async_cyc("R10", 1'b0, 8'h22, 8'h00, 1'b0, 8'h00);
        async_cyc("R10", 1'b0, 8'h8F, 8'h00, 1'b0, 8'h80);
        async_cyc("R10", 1'b1, 8'h8F, 8'h00, 1'b0, 8'h00);
        async_cyc("R10", 1'b0, 8'h22, 8'h00, 1'b1, 8'h78);

        // R5: switching write, then wait out the guard interval
        async_cyc("R5", 1'b1, 8'h0F, 8'h40, 1'b0, 8'h00);
        repeat (2) @(negedge clk);
        sync_cyc("R5", 1'b0, 8'h0F, 8'h00, 1'b0, 8'h40, 1'b1);
        chk("R6", {31'd0, gerr}, 32'd0);

        // R8: back-to-back synchronous accesses with chip enable held low
        sync_cyc("R8", 1'b1, 8'h31, 8'hA5, 1'b1, 8'h00, 1'b0);
        sync_cyc("R8", 1'b0, 8'h44, 8'h00, 1'b1, 8'h1E, 1'b0);
        sync_cyc("R8", 1'b1, 8'h8E, 8'h0C, 1'b1, 8'h00, 1'b1);

        // R9: clearing the mode bit does not leave synchronous mode
        sync_cyc("R9", 1'b1, 8'h8F, 8'h00, 1'b0, 8'h00, 1'b1);
        sync_cyc("R9", 1'b0, 8'h0F, 8'h00, 1'b0, 8'h40, 1'b1);

        // R9: reset restores handshaken mode
        do_reset();
        async_cyc("R9", 1'b0, 8'h0F, 8'h00, 1'b0, 8'h00);

        // R6: attempt a cycle inside the guard interval
        async_cyc("R5", 1'b1, 8'h8F, 8'h40, 1'b0, 8'h00);
        ce_n = 1'b0; wr = 1'b0; addr = 8'h22;
        @(negedge clk);
        chk("R6", {31'd0, dack}, 32'd0);
        chk("R6", {31'd0, wstb || rstb}, 32'd0);
        chk("R6", {31'd0, gerr}, 32'd1);
        ce_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R6", {30'd0, dack, wstb || rstb}, 32'd0);
        end
        sync_cyc("R6", 1'b0, 8'h22, 8'h00, 1'b1, 8'h78, 1'b1);
        chk("R6", {31'd0, gerr}, 32'd1);

        do_reset();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule